// File: doc/BRIEF.md
# Li-ion Charge Cycle Sequencer

This block decides, cycle by cycle, which phase of a lithium-ion charge cycle is in force. It takes comparator flags that have already been synchronised to its clock: input power present, battery below the precharge threshold, termination current reached, and battery below the recharge threshold. It also takes a regulation-loop-active flag for the input power or die temperature loop, a charger over-temperature flag and a charge-enable bit. From these it drives a charge-enable output, a precharge current select and a status code. Analog regulation stays outside the block.

Changes driven by the battery condition take effect only after the flag has held for a qualification window of `QUAL_CYC` clock cycles. The default is 22.5 ms at 50 MHz. Over-temperature, loss of power and clearing of charge-enable act at once. Two safety timers guard the cycle, and both derive from one programmable base count: the precharge limit is `base` cycles and the fast-charge limit is ten times that. While a regulation loop is active the timer advances at half rate, and a wall-clock counter caps the elapsed time at twice the limit. When a timer expires the block latches a fault.

Top module: `chg_ctrl`

## Requirements
- R1: After reset the status code is 0 (off) and both charge_on_o and pre_sel_o are low. The status codes are 0 off, 1 precharge, 2 fast charge, 3 done, 4 fault and 5 suspend.
- R2: In off, with power present and charge enabled, the next clock edge enters precharge if bat_low_i is high and fast charge if it is low.
- R3: Precharge moves to fast charge one edge after bat_low_i has been low for QUAL_CYC consecutive edges. A shorter low interval has no effect.
- R4: Fast charge falls back to precharge one edge after bat_low_i has been high for QUAL_CYC consecutive edges.
- R5: Fast charge enters done one edge after term_i has been high with rch_low_i low for QUAL_CYC consecutive edges. While rch_low_i is high, term_i is ignored.
- R6: In done, once rch_low_i has been high for QUAL_CYC consecutive edges, the next edge starts a new cycle (precharge or fast charge, chosen by bat_low_i).
- R7: The safety timer restarts on every entry into precharge or fast charge. It enters fault one edge after it has advanced base_i times in precharge, or 10*base_i times in fast charge.
- R8: While reg_loop_i is high the timer advances on every second edge. A wall-clock counter forces expiry at twice the limit.
- R9: tshut_i high in precharge or fast charge enters suspend on the next edge. The timer holds its count in suspend, and the block returns to the same phase on the edge after tshut_i clears.
- R10: Fault persists whatever the battery flags do. It is left only through off (power loss or charge-enable cleared), and the next cycle starts with fresh timers.
- R11: pwr_ok_i low or chg_en_i low returns the block to off on the next edge, from any state.
- R12: charge_on_o is high exactly in precharge and fast charge. pre_sel_o is high exactly in precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Input power present |
| chg_en_i | input | 1 | Charge enable bit |
| bat_low_i | input | 1 | Battery below the precharge-to-fast threshold |
| term_i | input | 1 | Charge current below the termination level |
| rch_low_i | input | 1 | Battery below the recharge threshold |
| reg_loop_i | input | 1 | Input power or thermal regulation loop active |
| tshut_i | input | 1 | Charger over-temperature |
| base_i | input | BASE_W | Precharge safety limit in clock cycles |
| charge_on_o | output | 1 | Charger enabled |
| pre_sel_o | output | 1 | Precharge current selected |
| state_o | output | 3 | Status code |

## Verification
Battery-flag pulses one edge shorter than the qualification window and pulses of the full window are applied in turn. This separates a qualifier that counts consecutive edges from one that merely latches the flag, and it shows the exact edge on which each phase change lands. Several timer runs are compared against each other: a plain run, a run with the regulation loop held active, and a run broken by an over-temperature pause. These show that the half-rate stretch and the hold in suspend move expiry by exactly the expected number of edges, while a fast-charge run confirms the tenfold limit. The termination flag is raised both with the recharge flag high and with it low, to show that termination counts only above the recharge threshold.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PRE   = 3'd1,
    ST_FAST  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4,
    ST_SUSP  = 3'd5
  } chg_state_e;

  localparam int unsigned NUM_QUAL = 4;
  localparam int unsigned Q_BATLOW = 0;
  localparam int unsigned Q_BATOK  = 1;
  localparam int unsigned Q_TERM   = 2;
  localparam int unsigned Q_RCH    = 3;
endpackage

// File: rtl/chg_qual.sv
module chg_qual #(
  parameter int unsigned QUAL_CYC = 1125000,
  parameter int unsigned N        = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] q_o
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q <= '0;
      else if (!flag_i[i])              cnt_q <= '0;
      else if (cnt_q != CW'(QUAL_CYC))  cnt_q <= cnt_q + 1'b1;
    end
    assign q_o[i] = (cnt_q == CW'(QUAL_CYC));
  end
endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
  parameter int unsigned BASE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              pre_i,
  input  logic              slow_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              expired_o
);
  localparam int unsigned TW = BASE_W + 5;

  logic [TW-1:0] base_x, lim, lim2;
  logic [TW-1:0] prog_q, wall_q;
  logic          half_q;

  assign base_x = TW'(base_i);
  assign lim    = pre_i ? base_x : (base_x << 3) + (base_x << 1);
  assign lim2   = lim << 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= '0;
      wall_q <= '0;
      half_q <= 1'b0;
    end else if (clr_i) begin
      prog_q <= '0;
      wall_q <= '0;
      half_q <= 1'b0;
    end else if (run_i) begin
      wall_q <= wall_q + 1'b1;
      half_q <= slow_i ? ~half_q : 1'b0;
      if (!slow_i || half_q) prog_q <= prog_q + 1'b1;
    end
  end

  // wall-clock ceiling bounds the stretch
  assign expired_o = (prog_q >= lim) || (wall_q >= lim2);
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pwr_ok_i,
  input  logic                chg_en_i,
  input  logic                tshut_i,
  input  logic                bat_low_i,
  input  logic [NUM_QUAL-1:0] qual_i,
  input  logic                tmr_exp_i,
  output chg_state_e          state_o,
  output logic                tmr_clr_o,
  output logic                tmr_run_o,
  output logic                tmr_pre_o
);
  chg_state_e state_q, state_d;
  logic       resume_pre_q, resume_pre_d;

  always_comb begin
    state_d      = state_q;
    resume_pre_d = resume_pre_q;
    if (!pwr_ok_i || !chg_en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = bat_low_i ? ST_PRE : ST_FAST;
        ST_PRE: begin
          if (tshut_i) begin
            state_d      = ST_SUSP;
            resume_pre_d = 1'b1;
          end else if (tmr_exp_i)        state_d = ST_FAULT;
          else if (qual_i[Q_BATOK])      state_d = ST_FAST;
        end
        ST_FAST: begin
          if (tshut_i) begin
            state_d      = ST_SUSP;
            resume_pre_d = 1'b0;
          end else if (tmr_exp_i)        state_d = ST_FAULT;
          else if (qual_i[Q_BATLOW])     state_d = ST_PRE;
          else if (qual_i[Q_TERM])       state_d = ST_DONE;
        end
        ST_SUSP: if (!tshut_i) state_d = resume_pre_q ? ST_PRE : ST_FAST;
        ST_DONE: if (qual_i[Q_RCH]) state_d = bat_low_i ? ST_PRE : ST_FAST;
        ST_FAULT: state_d = ST_FAULT;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_OFF;
      resume_pre_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      resume_pre_q <= resume_pre_d;
    end
  end

  // fresh timer on each phase entry, except a return from suspend
  assign tmr_clr_o = (state_d != state_q) && (state_q != ST_SUSP) &&
                     ((state_d == ST_PRE) || (state_d == ST_FAST));
  assign tmr_run_o = (state_q == ST_PRE) || (state_q == ST_FAST);
  assign tmr_pre_o = (state_q == ST_PRE);
  assign state_o   = state_q;
endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int unsigned BASE_W   = 16,
  parameter int unsigned QUAL_CYC = 1125000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              chg_en_i,
  input  logic              bat_low_i,
  input  logic              term_i,
  input  logic              rch_low_i,
  input  logic              reg_loop_i,
  input  logic              tshut_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              charge_on_o,
  output logic              pre_sel_o,
  output logic [2:0]        state_o
);
  logic [NUM_QUAL-1:0] flags, qual;
  logic                tmr_clr, tmr_run, tmr_pre, tmr_exp;
  chg_state_e          st;

  always_comb begin
    flags           = '0;
    flags[Q_BATLOW] = bat_low_i;
    flags[Q_BATOK]  = ~bat_low_i;
    flags[Q_TERM]   = term_i & ~rch_low_i;
    flags[Q_RCH]    = rch_low_i;
  end

  chg_qual #(.QUAL_CYC(QUAL_CYC), .N(NUM_QUAL)) u_qual (
    .clk_i (clk_i), .rst_ni(rst_ni), .flag_i(flags), .q_o(qual)
  );

  chg_timer #(.BASE_W(BASE_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .run_i    (tmr_run),
    .pre_i    (tmr_pre),
    .slow_i   (reg_loop_i),
    .base_i   (base_i),
    .expired_o(tmr_exp)
  );

  chg_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .chg_en_i (chg_en_i),
    .tshut_i  (tshut_i),
    .bat_low_i(bat_low_i),
    .qual_i   (qual),
    .tmr_exp_i(tmr_exp),
    .state_o  (st),
    .tmr_clr_o(tmr_clr),
    .tmr_run_o(tmr_run),
    .tmr_pre_o(tmr_pre)
  );

  assign state_o     = st;
  assign charge_on_o = (st == ST_PRE) || (st == ST_FAST);
  assign pre_sel_o   = (st == ST_PRE);
endmodule

// File: rtl/chg_ctrl_chk.sv
module chg_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_ok_i,
  input logic       chg_en_i,
  input logic       tshut_i,
  input logic       charge_on_o,
  input logic       pre_sel_o,
  input logic [2:0] state_o
);
  a_r11_off_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_ok_i || !chg_en_i) |=> (state_o == 3'd0));

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && pwr_ok_i && chg_en_i) |=> (state_o == 3'd1 || state_o == 3'd2));

  a_r9_tshut_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd1 || state_o == 3'd2) && tshut_i && pwr_ok_i && chg_en_i)
      |=> (state_o == 3'd5));

  a_r9_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && tshut_i && pwr_ok_i && chg_en_i) |=> (state_o == 3'd5));

  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && pwr_ok_i && chg_en_i) |=> (state_o == 3'd4));

  a_r12_pre_implies_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_sel_o |-> charge_on_o);

  a_r5_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> !charge_on_o);
endmodule

bind chg_ctrl chg_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_ok_i   (pwr_ok_i),
  .chg_en_i   (chg_en_i),
  .tshut_i    (tshut_i),
  .charge_on_o(charge_on_o),
  .pre_sel_o  (pre_sel_o),
  .state_o    (state_o)
);

// File: tb/sim_chg_ctrl.sv
module sim_chg_ctrl;
  localparam int BW = 16;
  localparam int QC = 4;
  localparam int B  = 20;

  localparam logic [2:0] S_OFF = 3'd0, S_PRE = 3'd1, S_FAST = 3'd2,
                         S_DONE = 3'd3, S_FAULT = 3'd4, S_SUSP = 3'd5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr = 1'b0, en = 1'b0, bat_low = 1'b1, term = 1'b0, rch = 1'b0;
  logic reg_loop = 1'b0, tshut = 1'b0;
  logic [BW-1:0] base = BW'(B);
  logic chg_on, pre_sel;
  logic [2:0] st;

  always #10 clk = ~clk;

  chg_ctrl #(.BASE_W(BW), .QUAL_CYC(QC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_i(pwr), .chg_en_i(en),
    .bat_low_i(bat_low), .term_i(term), .rch_low_i(rch),
    .reg_loop_i(reg_loop), .tshut_i(tshut), .base_i(base),
    .charge_on_o(chg_on), .pre_sel_o(pre_sel), .state_o(st)
  );

  typedef struct {
    logic [2:0] st;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic [2:0] s, string tag);
    exp_q.push_back('{s, tag});
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic e_on, e_pre;
        e = exp_q.pop_front();
        e_on  = (e.st == S_PRE) || (e.st == S_FAST);
        e_pre = (e.st == S_PRE);
        n_chk++;
        if (st !== e.st) begin
          n_fail++;
          $display("FAIL %s state=%0d expected=%0d", e.tag, st, e.st);
        end
        n_chk++;
        if (chg_on !== e_on || pre_sel !== e_pre) begin
          n_fail++;
          $display("FAIL R12 (%s) on/pre=%0b%0b expected=%0b%0b", e.tag, chg_on, pre_sel, e_on, e_pre);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    chk(S_OFF, "R1 reset");

    // R2 start in precharge, R7 precharge expiry
    pwr = 1'b1; en = 1'b1;
    step(1);      chk(S_PRE, "R2 start pre");
    step(B);      chk(S_PRE, "R7 pre before limit");
    step(1);      chk(S_FAULT, "R7 pre expiry");

    // R10 fault sticky
    bat_low = 1'b0;
    step(QC + 3); chk(S_FAULT, "R10 fault sticky");
    en = 1'b0; bat_low = 1'b1;
    step(1);      chk(S_OFF, "R11 enable cleared");
    en = 1'b1;
    step(1);      chk(S_PRE, "R10 restart");
    step(B);      chk(S_PRE, "R10 fresh timer");
    step(1);      chk(S_FAULT, "R10 fresh timer expiry");

    // R8 half rate under regulation loop
    en = 1'b0;
    step(1);      chk(S_OFF, "R11 exit fault");
    reg_loop = 1'b1; en = 1'b1;
    step(1);      chk(S_PRE, "R8 start");
    step(2 * B);  chk(S_PRE, "R8 stretched");
    step(1);      chk(S_FAULT, "R8 stretched expiry");
    reg_loop = 1'b0;

    // R3 qualification, R4 fall back
    en = 1'b0;
    step(1);      chk(S_OFF, "R11 off");
    en = 1'b1;
    step(1);      chk(S_PRE, "R2 pre");
    bat_low = 1'b0;
    step(QC - 1);
    bat_low = 1'b1;
    step(1);      chk(S_PRE, "R3 short pulse ignored");
    bat_low = 1'b0;
    step(QC);     chk(S_PRE, "R3 before window");
    step(1);      chk(S_FAST, "R3 to fast");
    bat_low = 1'b1;
    step(QC);     chk(S_FAST, "R4 before window");
    step(1);      chk(S_PRE, "R4 back to pre");

    // R9 suspend in precharge holds the timer
    step(2);
    tshut = 1'b1;
    step(1);      chk(S_SUSP, "R9 suspend");
    step(10);     chk(S_SUSP, "R9 held");
    tshut = 1'b0;
    step(1);      chk(S_PRE, "R9 resume pre");
    step(17);     chk(S_PRE, "R9 timer held");
    step(1);      chk(S_FAULT, "R9 expiry shifted");

    // fast charge path, R5 R6
    en = 1'b0;
    step(1);      chk(S_OFF, "R11 off");
    bat_low = 1'b0; en = 1'b1;
    step(1);      chk(S_FAST, "R2 start fast");
    tshut = 1'b1;
    step(1);      chk(S_SUSP, "R9 suspend fast");
    tshut = 1'b0;
    step(1);      chk(S_FAST, "R9 resume fast");
    rch = 1'b1; term = 1'b1;
    step(QC + 3); chk(S_FAST, "R5 term ignored below recharge");
    rch = 1'b0;
    step(QC);     chk(S_FAST, "R5 before window");
    step(1);      chk(S_DONE, "R5 done");
    term = 1'b0; rch = 1'b1;
    step(QC);     chk(S_DONE, "R6 before window");
    step(1);      chk(S_FAST, "R6 recharge");

    // R11 power loss, R7 fast expiry
    pwr = 1'b0;
    step(1);      chk(S_OFF, "R11 power loss");
    rch = 1'b0;
    pwr = 1'b1;
    step(1);      chk(S_FAST, "R2 fast");
    step(10 * B); chk(S_FAST, "R7 fast before limit");
    step(1);      chk(S_FAULT, "R7 fast expiry");

    step(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule